// File: doc/BRIEF.md
# Coprocessor Board Control-Status Register Bank

This block is the host-visible register bank of a graphics coprocessor board. A 32-bit host bus writes and reads it, decoding only the low 14 address bits. It holds a primary control word with interrupt masks, sticky pending flags and live blanking levels. It also holds a host-interrupt word, a spare control word, a slot-identity word, a DMA control word, fourteen DMA address and width registers, a video timing word and a DRAM size word. The DMA engine, the video timing generator and the DRAM controller sit outside the block and only take their settings from here.

Two side effects come from host writes. Setting the reset bit of the primary control word produces a one-cycle coprocessor reset pulse. Setting a pending flag together with its mask produces a one-cycle local interrupt request. A display-blank input and a video-blank input each pass through a small two-state edge tracker (states BLK_IDLE and BLK_ACTIVE). The transition BLK_IDLE to BLK_ACTIVE, taken when the input is high, marks a blank start. The transition BLK_ACTIVE to BLK_IDLE, taken when the input is low, marks a blank end. A blank start sets a sticky flag and may raise the local interrupt. The tracker state is the live level bit that is read back.

Top module: `gfx_csr_bank`

## Requirements
- R1: After reset the primary word (offset 0x0000) reads 0x00000002. The slot word (0x0030) reads STEPPING in bits 7:4 and the `slot_in` value in bits 3:0. Every other register reads 0, and `cop_rst`, `local_irq` and `host_irq` are low.
- R2: The registers sit at these offsets of the 14-bit address: primary 0x0000, host word 0x0010, spare 0x0020, slot 0x0030, DMA control 0x1000, DMA registers 0x1010 to 0x10F0 in steps of 0x10, video timing 0x2000, DRAM size 0x3000. A read of any other offset returns 0. A write to any other offset changes no register.
- R3: A write to 0x0000 with bit 0 set drives `cop_rst` high for exactly the cycle after the write edge. Bit 0 always reads back as 0.
- R4: A write to 0x0000 drives `local_irq` high for the cycle after the write edge when the written data has both bits 3 and 2 set (coprocessor pending with its mask), or both bits 5 and 4 set (bus-error pending with its mask).
- R5: `host_irq` equals bit 0 of the last value written to 0x0010, from the cycle after that write.
- R6: Display blank start sets bit 7 (sticky flag) and bit 8 (live level) of the primary word, and pulses `local_irq` in the next cycle if bit 6 (its mask) is set. Display blank end clears only bit 8.
- R7: Video blank start sets bit 10 and bit 11 and pulses `local_irq` if bit 9 is set. Video blank end clears only bit 11.
- R8: Host writes cannot change bits 8 and 11 of the primary word, and bits 31:13 of that word read 0. Bits 1 to 7, 9, 10 and 12 store what is written.
- R9: Offset 0x10D0 and offset 0x10B0 address the same storage: a write through either one is read back through both.
- R10: When a blank start and a host write to 0x0000 happen in the same cycle, the write sets the stored bits and the blank start still sets its sticky flag. The interrupt decision uses the mask bit as written in that cycle.
- R11: The host, spare, slot, DMA control, DMA, video timing and DRAM words store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_in | input | 4 | Board slot number, captured into the slot word at reset |
| bus_addr | input | 14 | Host byte address, low 14 bits |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| disp_blank | input | 1 | Display blanking level |
| vid_blank | input | 1 | Video-input blanking level |
| cop_rst | output | 1 | One-cycle coprocessor reset pulse |
| local_irq | output | 1 | One-cycle local interrupt request |
| host_irq | output | 1 | Host interrupt line level |

## Verification
Several checks run on every cycle. The reset pulse is checked to follow only a qualifying write. The host line is checked to follow the written bit and to hold still when its word is not written. The reset bit is checked never to read as set. Blank edges are checked to set the sticky flag and level, and to clear the level alone. The merge of a blank start with a same-cycle write, the alias pair, the unmapped-offset behaviour and the exact read-back values of every word need whole scenarios, which the bench drives against its own register model.

// File: rtl/gfx_csr_pkg.sv
package gfx_csr_pkg;
    localparam int DW = 32;
    localparam int AW = 14;

    localparam logic [AW-1:0] OFS_PRIMARY = 14'h0000;
    localparam logic [AW-1:0] OFS_HOST    = 14'h0010;
    localparam logic [AW-1:0] OFS_SPARE   = 14'h0020;
    localparam logic [AW-1:0] OFS_SLOT    = 14'h0030;
    localparam logic [AW-1:0] OFS_DMACTL  = 14'h1000;
    localparam logic [AW-1:0] OFS_VTIME   = 14'h2000;
    localparam logic [AW-1:0] OFS_DRAMSZ  = 14'h3000;

    // primary word bit positions
    localparam int B_RST      = 0;
    localparam int B_COP_MSK  = 2;
    localparam int B_COP_PND  = 3;
    localparam int B_BERR_MSK = 4;
    localparam int B_BERR_PND = 5;
    localparam int B_DBL_MSK  = 6;
    localparam int B_DBL_PND  = 7;
    localparam int B_DBL_LVL  = 8;
    localparam int B_VBL_MSK  = 9;
    localparam int B_VBL_PND  = 10;
    localparam int B_VBL_LVL  = 11;

    localparam logic [DW-1:0] PRIMARY_WMASK = 32'h0000_16FE;
    localparam logic [DW-1:0] PRIMARY_INIT  = 32'h0000_0002;

    typedef enum logic {BLK_IDLE, BLK_ACTIVE} blank_state_e;

    // DMA row number (address bits 7:4, 1..15) to storage index, row 13 aliases row 11
    function automatic int dma_index(input logic [3:0] row);
        if (row == 4'd13)
            return 10;
        else if (row < 4'd13)
            return int'(row) - 1;
        else
            return int'(row) - 2;
    endfunction
endpackage

// File: rtl/gfx_blank_tracker.sv
module gfx_blank_tracker
    import gfx_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blank_in,
    output logic start_o,
    output logic level_o
);
    blank_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BLK_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        level_o = 1'b0;
        unique case (state_q)
            BLK_IDLE: begin
                if (blank_in) begin
                    state_d = BLK_ACTIVE;
                    start_o = 1'b1;
                end
            end
            BLK_ACTIVE: begin
                level_o = 1'b1;
                if (!blank_in)
                    state_d = BLK_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/gfx_primary_word.sv
module gfx_primary_word
    import gfx_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          disp_start_i,
    input  logic          disp_level_i,
    input  logic          vid_start_i,
    input  logic          vid_level_i,
    output logic [DW-1:0] view_o,
    output logic          cop_rst_o,
    output logic          lirq_o
);
    logic [DW-1:0] store_q, merged, next_val;
    logic          rst_d, lirq_d, sw_irq;

    always_comb begin
        merged   = wr_i ? (wdata_i & PRIMARY_WMASK) : (store_q & PRIMARY_WMASK);
        next_val = merged;
        if (disp_start_i) next_val[B_DBL_PND] = 1'b1;
        if (vid_start_i)  next_val[B_VBL_PND] = 1'b1;
        sw_irq   = wr_i && ((wdata_i[B_COP_PND]  && wdata_i[B_COP_MSK]) ||
                            (wdata_i[B_BERR_PND] && wdata_i[B_BERR_MSK]));
        lirq_d   = sw_irq || (disp_start_i && merged[B_DBL_MSK])
                          || (vid_start_i  && merged[B_VBL_MSK]);
        rst_d    = wr_i && wdata_i[B_RST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q   <= PRIMARY_INIT;
            cop_rst_o <= 1'b0;
            lirq_o    <= 1'b0;
        end else begin
            store_q   <= next_val;
            cop_rst_o <= rst_d;
            lirq_o    <= lirq_d;
        end
    end

    always_comb begin
        view_o            = store_q;
        view_o[B_DBL_LVL] = disp_level_i;
        view_o[B_VBL_LVL] = vid_level_i;
    end
endmodule

// File: rtl/gfx_word_store.sv
module gfx_word_store
    import gfx_csr_pkg::*;
#(
    parameter int          NUM_DMA  = 14,
    parameter logic [3:0]  STEPPING = 4'h3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    slot_in,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] host_o,
    output logic [DW-1:0] spare_o,
    output logic [DW-1:0] slot_o,
    output logic [DW-1:0] dmactl_o,
    output logic [DW-1:0] vtime_o,
    output logic [DW-1:0] dramsz_o,
    output logic          dma_hit_o,
    output logic [DW-1:0] dma_rd_o
);
    localparam int IW = $clog2(NUM_DMA);

    logic [DW-1:0] dma_q [NUM_DMA];
    logic [IW-1:0] dma_sel;

    assign dma_hit_o = (addr_i[13:8] == 6'h10) && (addr_i[3:0] == 4'h0) && (addr_i[7:4] != 4'h0);
    assign dma_sel   = IW'(dma_index(addr_i[7:4]));
    assign dma_rd_o  = dma_hit_o ? dma_q[dma_sel] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_o   <= '0;
            spare_o  <= '0;
            slot_o   <= {{(DW-8){1'b0}}, STEPPING, slot_in};
            dmactl_o <= '0;
            vtime_o  <= '0;
            dramsz_o <= '0;
        end else if (wr_i) begin
            if (addr_i == OFS_HOST)   host_o   <= wdata_i;
            if (addr_i == OFS_SPARE)  spare_o  <= wdata_i;
            if (addr_i == OFS_SLOT)   slot_o   <= wdata_i;
            if (addr_i == OFS_DMACTL) dmactl_o <= wdata_i;
            if (addr_i == OFS_VTIME)  vtime_o  <= wdata_i;
            if (addr_i == OFS_DRAMSZ) dramsz_o <= wdata_i;
        end
    end

    for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
        always_ff @(posedge clk) begin
            if (!rst_n)
                dma_q[g] <= '0;
            else if (wr_i && dma_hit_o && (int'(dma_sel) == g))
                dma_q[g] <= wdata_i;
        end
    end
endmodule

// File: rtl/gfx_csr_bank.sv
module gfx_csr_bank
    import gfx_csr_pkg::*;
#(
    parameter logic [3:0] STEPPING = 4'h3
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  slot_in,
    input  logic [13:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        disp_blank,
    input  logic        vid_blank,
    output logic        cop_rst,
    output logic        local_irq,
    output logic        host_irq
);
    localparam int NUM_DMA = 14;

    logic          disp_start, disp_level, vid_start, vid_level;
    logic [DW-1:0] c0_view, host_w, spare_w, slot_w, dmactl_w, vtime_w, dramsz_w, dma_rd;
    logic          dma_hit, wr_primary;

    assign wr_primary = bus_wr && (bus_addr == OFS_PRIMARY);

    gfx_blank_tracker u_disp (
        .clk(clk), .rst_n(rst_n), .blank_in(disp_blank),
        .start_o(disp_start), .level_o(disp_level)
    );

    gfx_blank_tracker u_vid (
        .clk(clk), .rst_n(rst_n), .blank_in(vid_blank),
        .start_o(vid_start), .level_o(vid_level)
    );

    gfx_primary_word u_prim (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_primary), .wdata_i(bus_wdata),
        .disp_start_i(disp_start), .disp_level_i(disp_level),
        .vid_start_i(vid_start), .vid_level_i(vid_level),
        .view_o(c0_view), .cop_rst_o(cop_rst), .lirq_o(local_irq)
    );

    gfx_word_store #(.NUM_DMA(NUM_DMA), .STEPPING(STEPPING)) u_store (
        .clk(clk), .rst_n(rst_n), .slot_in(slot_in),
        .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .host_o(host_w), .spare_o(spare_w), .slot_o(slot_w),
        .dmactl_o(dmactl_w), .vtime_o(vtime_w), .dramsz_o(dramsz_w),
        .dma_hit_o(dma_hit), .dma_rd_o(dma_rd)
    );

    assign host_irq = host_w[0];

    always_comb begin
        if (dma_hit)
            bus_rdata = dma_rd;
        else begin
            case (bus_addr)
                OFS_PRIMARY: bus_rdata = c0_view;
                OFS_HOST:    bus_rdata = host_w;
                OFS_SPARE:   bus_rdata = spare_w;
                OFS_SLOT:    bus_rdata = slot_w;
                OFS_DMACTL:  bus_rdata = dmactl_w;
                OFS_VTIME:   bus_rdata = vtime_w;
                OFS_DRAMSZ:  bus_rdata = dramsz_w;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gfx_csr_bank_chk.sv
module gfx_csr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] c0_view,
    input logic        disp_blank,
    input logic        vid_blank,
    input logic        cop_rst,
    input logic        host_irq
);
    AST_RST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cop_rst |-> $past(bus_wr && bus_addr == 14'h0000 && bus_wdata[0])); // R3

    AST_RST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !c0_view[0]); // R3

    AST_HOST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 14'h0010) |=> (host_irq == $past(bus_wdata[0]))); // R5

    AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 14'h0010) |=> $stable(host_irq)); // R5

    AST_DBL_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_blank) |=> (c0_view[7] && c0_view[8])); // R6

    AST_DBL_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_blank) |=> !c0_view[8]); // R6

    AST_VBL_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_blank) |=> (c0_view[10] && c0_view[11])); // R7
endmodule

bind gfx_csr_bank gfx_csr_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .c0_view(c0_view), .disp_blank(disp_blank),
    .vid_blank(vid_blank), .cop_rst(cop_rst), .host_irq(host_irq)
);

// File: tb/sim_gfx_csr_bank.sv
`timescale 1ns/1ps
module sim_gfx_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  slot_in = 4'h5;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        disp_blank = 1'b0, vid_blank = 1'b0;
    logic        cop_rst, local_irq, host_irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_c0, m_host, m_spare, m_slot, m_dctl, m_vt, m_dr;
    logic [31:0] m_dma [16];

    always #4 clk = ~clk;

    gfx_csr_bank #(.STEPPING(4'h3)) u0 (
        .clk(clk), .rst_n(rst_n), .slot_in(slot_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .disp_blank(disp_blank), .vid_blank(vid_blank),
        .cop_rst(cop_rst), .local_irq(local_irq), .host_irq(host_irq)
    );

    function automatic bit is_dma(input logic [13:0] a);
        return a[13:8] == 6'h10 && a[3:0] == 4'h0 && a[7:4] != 4'h0;
    endfunction

    function automatic int row_of(input logic [13:0] a);
        return (a[7:4] == 4'hD) ? 11 : int'(a[7:4]);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [13:0] a);
        if (is_dma(a)) return m_dma[row_of(a)];
        case (a)
            14'h0000: return m_c0;
            14'h0010: return m_host;
            14'h0020: return m_spare;
            14'h0030: return m_slot;
            14'h1000: return m_dctl;
            14'h2000: return m_vt;
            14'h3000: return m_dr;
            default:  return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [13:0] a, input logic [31:0] d);
        if (is_dma(a)) m_dma[row_of(a)] = d;
        case (a)
            14'h0000: m_c0 = (d & 32'h16FE) | (m_c0 & 32'h0900);
            14'h0010: m_host = d;
            14'h0020: m_spare = d;
            14'h0030: m_slot = d;
            14'h1000: m_dctl = d;
            14'h2000: m_vt = d;
            14'h3000: m_dr = d;
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [13:0] a, input logic [31:0] d, input string req);
        logic er, ei;
        er = (a == 14'h0000) && d[0];
        ei = (a == 14'h0000) && ((d[3] && d[2]) || (d[5] && d[4]));
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(a, d);
        chk({req, " R3 rst pulse"}, {31'b0, cop_rst}, {31'b0, er});
        chk({req, " R4 local irq"}, {31'b0, local_irq}, {31'b0, ei});
        chk({req, " R5 host line"}, {31'b0, host_irq}, {31'b0, m_host[0]});
        @(posedge clk); #1;
        chk({req, " R3 pulse ends"}, {31'b0, cop_rst}, 32'h0);
    endtask

    task automatic do_read(input logic [13:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(req, bus_rdata, exp_rd(a));
    endtask

    // drive a blank input, apply the model and check the interrupt
    task automatic set_blank(input bit vid, input bit v, input string req);
        bit rise, ei;
        @(negedge clk);
        if (vid) begin rise = v && !vid_blank; vid_blank = v; end
        else     begin rise = v && !disp_blank; disp_blank = v; end
        @(posedge clk); #1;
        ei = 1'b0;
        if (vid) begin
            if (rise) begin m_c0[10] = 1'b1; m_c0[11] = 1'b1; ei = m_c0[9]; end
            if (!v) m_c0[11] = 1'b0;
        end else begin
            if (rise) begin m_c0[7] = 1'b1; m_c0[8] = 1'b1; ei = m_c0[6]; end
            if (!v) m_c0[8] = 1'b0;
        end
        chk({req, " blank irq"}, {31'b0, local_irq}, {31'b0, ei});
    endtask

    initial begin
        m_c0 = 32'h2; m_host = 0; m_spare = 0; m_slot = 32'h35; m_dctl = 0; m_vt = 0; m_dr = 0;
        for (int i = 0; i < 16; i++) m_dma[i] = 0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        do_read(14'h0000, "R1 primary reset");
        do_read(14'h0030, "R1 slot reset");
        do_read(14'h10F0, "R1 dma reset");
        chk("R1 outputs low", {29'b0, cop_rst, local_irq, host_irq}, 32'h0);

        // R3 reset bit self-clears
        do_write(14'h0000, 32'h0000_0003, "R3");
        do_read(14'h0000, "R3 bit0 reads 0");

        // R4 both interrupt pairs, and lone pending without mask
        do_write(14'h0000, 32'h0000_000C, "R4 cop pair");
        do_write(14'h0000, 32'h0000_0030, "R4 berr pair");
        do_write(14'h0000, 32'h0000_0028, "R4 unmatched");

        // R5 host line
        do_write(14'h0010, 32'h0000_0001, "R5 set");
        do_write(14'h0010, 32'hFFFF_FFFE, "R5 clear");

        // R8 read-only and upper bits
        do_write(14'h0000, 32'hFFFF_FFFF, "R8 all ones");
        do_read(14'h0000, "R8 ro bits");
        do_write(14'h0000, 32'h0000_0000, "R8 clear");

        // R6 display blanking, mask off then on
        set_blank(1'b0, 1'b1, "R6 start nomask");
        do_read(14'h0000, "R6 flag+level");
        set_blank(1'b0, 1'b0, "R6 end");
        do_read(14'h0000, "R6 only level cleared");
        do_write(14'h0000, 32'h0000_0040, "R6 mask on");
        set_blank(1'b0, 1'b1, "R6 start masked");
        set_blank(1'b0, 1'b0, "R6 end2");

        // R7 video blanking
        do_write(14'h0000, 32'h0000_0200, "R7 mask on");
        set_blank(1'b1, 1'b1, "R7 start masked");
        do_read(14'h0000, "R7 flag+level");
        set_blank(1'b1, 1'b0, "R7 end");
        do_read(14'h0000, "R7 only level cleared");

        // R10 same-cycle write and blank start: flag kept, written mask (0) used
        @(negedge clk);
        bus_addr = 14'h0000; bus_wdata = 32'h0; bus_wr = 1'b1; disp_blank = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        m_c0 = 32'h0000_0180;
        chk("R10 merge irq", {31'b0, local_irq}, 32'h0);
        do_read(14'h0000, "R10 merge value");
        set_blank(1'b0, 1'b0, "R10 end");

        // R9 alias
        do_write(14'h10D0, 32'hCAFE_0001, "R9 via alias");
        do_read(14'h10B0, "R9 read base");
        do_write(14'h10B0, 32'h1234_5678, "R9 via base");
        do_read(14'h10D0, "R9 read alias");

        // R2 unmapped offsets
        do_write(14'h0004, 32'hFFFF_FFFF, "R2 unmapped write");
        do_read(14'h0004, "R2 unmapped read");
        do_read(14'h0000, "R2 primary untouched");
        do_read(14'h1008, "R2 near dma");

        // R11 / R2 random traffic over mapped and unmapped offsets
        for (int i = 0; i < 400; i++) begin
            logic [13:0] a;
            logic [31:0] d;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0: a = 14'h0000;
                1: a = 14'h0010;
                2: a = 14'h0020;
                3: a = 14'h0030;
                4: a = 14'h1000;
                5: a = 14'h2000;
                6: a = 14'h3000;
                7, 8: a = {6'h10, 4'($urandom_range(1, 15)), 4'h0};
                default: a = 14'($urandom);
            endcase
            d = $urandom;
            if ($urandom_range(0, 1) == 0)
                do_write(a, d, "R11 random write");
            else
                do_read(a, "R11 random read");
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule